// File: doc/BRIEF.md
# Strap-Configured Host Bus Decoder

This block sits between a generic host bus and two internal targets: a file of sixteen 16-bit control registers and a 128 KB display-memory window. Its bus modes and match addresses are not fixed at build time. They come from a 16-bit strap word that is sampled while reset is held and frozen when reset is released. The strap selects an 8-bit or 16-bit host bus, optional swapping of the two bytes on a 16-bit bus, direct or indexed register addressing, the I/O base address, and the 3-bit tag of the memory window.

Every host access is decoded combinationally into a register access or a memory access. The host data is steered onto an even byte lane (bits 7:0) and an odd byte lane (bits 15:8). Read data comes back through the same steering. A memory cycle can hold the host in wait states for a programmable number of clocks before the memory strobe reaches the array. During that time the shared READY line is driven low. At all other times it is released, which is modelled as an output-enable.

Top module: `hbus_decoder`

## Requirements
- R1: While `rst_n` is low and for the two synchronizing clocks after it rises, `cfg_pins` is sampled every clock. The value held at the last of those clocks configures the block. Later changes on `cfg_pins` have no effect until the next reset.
- R2: While the synchronized reset is active, `reg_wr`, `reg_rd`, `mem_wr`, `mem_rd`, `dbus_oe` and `ready_oe` are all low, whatever the bus inputs are.
- R3: With strap bit 0 = 0 (8-bit bus), `addr[0]` selects the lane: 0 selects even, 1 selects odd. Write data is taken from `dbus_in[7:0]` only. `dbus_in[15:8]` and `bhe_n` are ignored. Read data returns on `dbus_out[7:0]` with `dbus_out[15:8]` = 0.
- R4: With strap bit 0 = 1 (16-bit bus), the even lane is enabled when `addr[0]`=0 and the odd lane when `bhe_n`=0. Byte enables are reported as {odd, even}.
- R5: Strap bit 3 = 1 exchanges the two bytes between the host bus and the lanes, in both directions, in 16-bit mode only.
- R6: With strap bit 1 = 1 (direct), an I/O access with `io_cs_n` low hits when the word offset `addr[9:1]` − strap[12:4] lies in 0..15. That offset is the register number. Any other offset is ignored.
- R7: With strap bit 1 = 0 (indexed), only the word `addr[9:1]` = strap[12:4] hits. The even lane is a 5-bit index port: bits 4:1 give the register and bit 0 gives the byte, 1 meaning the high byte. A written index takes effect one clock after the write strobe ends. The odd lane reads or writes the selected byte of the selected register.
- R8: A memory access with `mem_cs_n` low hits only when `addr[19:17]` = strap[15:13]. It presents `addr[16:1]` as the word address.
- R9: A memory access that hits drives READY (`ready_oe`=1, `ready_o`=0) for exactly `mem_wait` clocks, counted from its first strobe clock. With `mem_wait`=0 there is no wait state.
- R10: `mem_wr` or `mem_rd` asserts only after the wait count has elapsed. It stays asserted until the host strobe ends.
- R11: `dbus_oe` is high only during a decoded register or memory read. When it is low, `dbus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is asserted |
| cfg_pins | input | 16 | Strap word |
| io_cs_n | input | 1 | I/O chip select, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| mem_cs_n | input | 1 | Memory chip select, active low |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| bhe_n | input | 1 | Byte-high enable, active low |
| addr | input | 20 | Host byte address |
| dbus_in | input | 16 | Host write data |
| dbus_out | output | 16 | Host read data |
| dbus_oe | output | 1 | Host data bus drive enable |
| mem_wait | input | 4 | Wait clocks inserted on each memory access |
| ready_o | output | 1 | READY level (low while waiting) |
| ready_oe | output | 1 | READY drive enable; released otherwise |
| reg_addr | output | 4 | Selected register |
| reg_be | output | 2 | Register byte enables {odd, even} |
| reg_wr | output | 1 | Register write |
| reg_rd | output | 1 | Register read |
| reg_wdata | output | 16 | Register write data on lanes |
| reg_rdata | input | 16 | Register read data on lanes |
| mem_addr | output | 16 | Memory word address in window |
| mem_be | output | 2 | Memory byte enables {odd, even} |
| mem_wr | output | 1 | Memory write, after wait |
| mem_rd | output | 1 | Memory read, after wait |
| mem_wdata | output | 16 | Memory write data on lanes |
| mem_rdata | input | 16 | Memory read data on lanes |

## Verification
Wrong captured straps show up on the first host access after reset. They appear as a missed or misplaced register hit, a lane enable on the wrong side, or swapped bytes. A wrong index register is seen on the next odd-lane access, which reaches the wrong register or byte. It can also be seen directly by reading the index port back. A wrong wait counter shows at once in the count of clocks with READY driven, and in the clock where the memory strobe appears, so each memory access is watched clock by clock.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANE_W  = 2 * BYTE_W;
  localparam int STRAP_W = 16;

  typedef struct packed {
    logic [2:0] mem_tag;
    logic [8:0] io_base;
    logic       swap;
    logic       spare;
    logic       direct;
    logic       wide;
  } strap_t;
endpackage

// File: rtl/hbus_reset_strap.sv
module hbus_reset_strap #(
  parameter int SW        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cfg_pins,
  output logic          rst_sync_n,
  output logic [SW-1:0] strap_q
);
  logic [SYNC_DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_DEPTH-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[SYNC_DEPTH-1];

  // sampled every clock while held in reset; frozen after release
  always_ff @(posedge clk) begin
    if (!rst_sync_n) strap_q <= cfg_pins;
  end
endmodule

// File: rtl/hbus_lane_steer.sv
module hbus_lane_steer #(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          wide,
  input  logic          swap,
  input  logic          a0,
  input  logic          bhe_n,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] lane_rdata,
  output logic [1:0]    be,
  output logic [DW-1:0] lane_wdata,
  output logic [DW-1:0] host_rdata
);
  always_comb begin
    if (wide) begin
      be = {~bhe_n, ~a0};
      if (swap) begin
        lane_wdata = {host_wdata[BW-1:0], host_wdata[DW-1:BW]};
        host_rdata = {lane_rdata[BW-1:0], lane_rdata[DW-1:BW]};
      end else begin
        lane_wdata = host_wdata;
        host_rdata = lane_rdata;
      end
    end else begin
      be         = a0 ? 2'b10 : 2'b01;
      lane_wdata = {host_wdata[BW-1:0], host_wdata[BW-1:0]};
      host_rdata = {{BW{1'b0}}, (a0 ? lane_rdata[DW-1:BW] : lane_rdata[BW-1:0])};
    end
  end
endmodule

// File: rtl/hbus_io_decode.sv
module hbus_io_decode #(
  parameter int IO_AW = 10,
  parameter int NREG  = 16,
  parameter int BW    = 8,
  localparam int RAW  = $clog2(NREG),
  localparam int IXW  = RAW + 1,
  localparam int OFW  = IO_AW - 1,
  localparam int DW   = 2 * BW
) (
  input  logic           clk,
  input  logic           rst_sync_n,
  input  logic           active,
  input  logic           direct,
  input  logic [OFW-1:0] io_base,
  input  logic [IO_AW-1:0] addr,
  input  logic           io_cs_n,
  input  logic           io_rd_n,
  input  logic           io_wr_n,
  input  logic [1:0]     be,
  input  logic [DW-1:0]  lane_wdata,
  input  logic [DW-1:0]  reg_rdata,
  output logic [RAW-1:0] reg_addr,
  output logic [1:0]     reg_be,
  output logic           reg_wr,
  output logic           reg_rd,
  output logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  rd_lanes,
  output logic           rd_hit
);
  logic [IXW-1:0] idx_q, idx_d, idx_new_q, idx_new_d;
  logic           idx_wr_q;
  logic [OFW-1:0] offset;
  logic           io_cyc, hit_dir, hit_idx, data_lane, idx_wr;
  logic [BW-1:0]  sel_byte;

  assign io_cyc  = active & ~io_cs_n & (~io_rd_n | ~io_wr_n);
  assign offset  = addr[IO_AW-1:1] - io_base;
  assign hit_dir = direct & (offset[OFW-1:RAW] == '0);
  assign hit_idx = ~direct & (addr[IO_AW-1:1] == io_base);
  assign data_lane = hit_idx & be[1];
  assign idx_wr  = io_cyc & ~io_wr_n & hit_idx & be[0];
  assign sel_byte = idx_q[0] ? reg_rdata[DW-1:BW] : reg_rdata[BW-1:0];

  always_comb begin
    if (hit_dir) begin
      reg_addr  = offset[RAW-1:0];
      reg_be    = be;
      reg_wdata = lane_wdata;
      rd_lanes  = reg_rdata;
    end else begin
      reg_addr  = idx_q[IXW-1:1];
      reg_be    = data_lane ? (idx_q[0] ? 2'b10 : 2'b01) : 2'b00;
      reg_wdata = {lane_wdata[DW-1:BW], lane_wdata[DW-1:BW]};
      rd_lanes  = {(data_lane ? sel_byte : {BW{1'b0}}),
                   (be[0] ? {{(BW-IXW){1'b0}}, idx_q} : {BW{1'b0}})};
    end
  end

  assign reg_wr = io_cyc & ~io_wr_n & (hit_dir | data_lane) & (reg_be != 2'b00);
  assign reg_rd = io_cyc & ~io_rd_n & (hit_dir | data_lane) & (reg_be != 2'b00);
  assign rd_hit = io_cyc & ~io_rd_n & (hit_dir | hit_idx);

  // index commits one clock after its write strobe ends
  always_comb begin
    idx_new_d = idx_wr ? lane_wdata[IXW-1:0] : idx_new_q;
    idx_d     = (idx_wr_q & ~idx_wr) ? idx_new_q : idx_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q     <= '0;
      idx_new_q <= '0;
      idx_wr_q  <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      idx_new_q <= idx_new_d;
      idx_wr_q  <= idx_wr;
    end
  end
endmodule

// File: rtl/hbus_mem_wait.sv
module hbus_mem_wait #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_sync_n,
  input  logic          mem_act,
  input  logic [CW-1:0] wait_clks,
  output logic          waiting
);
  logic          act_q, act_d, pend_q, pend_d, first;
  logic [CW-1:0] cnt_q, cnt_d;

  assign first   = mem_act & ~act_q & (wait_clks != '0);
  assign waiting = mem_act & (first | pend_q);

  always_comb begin
    act_d  = mem_act;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!mem_act) begin
      pend_d = 1'b0;
    end else if (!act_q) begin
      cnt_d  = wait_clks - 1'b1;
      pend_d = (wait_clks > 1);
    end else if (pend_q) begin
      cnt_d  = cnt_q - 1'b1;
      pend_d = (cnt_q != 1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/hbus_decoder.sv
module hbus_decoder
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_AW  = 10,
  parameter int NREG   = 16,
  parameter int WAIT_W = 4,
  localparam int RAW   = $clog2(NREG),
  localparam int MAW   = ADDR_W - 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STRAP_W-1:0]  cfg_pins,
  input  logic                io_cs_n,
  input  logic                io_rd_n,
  input  logic                io_wr_n,
  input  logic                mem_cs_n,
  input  logic                mem_rd_n,
  input  logic                mem_wr_n,
  input  logic                bhe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LANE_W-1:0]   dbus_in,
  output logic [LANE_W-1:0]   dbus_out,
  output logic                dbus_oe,
  input  logic [WAIT_W-1:0]   mem_wait,
  output logic                ready_o,
  output logic                ready_oe,
  output logic [RAW-1:0]      reg_addr,
  output logic [1:0]          reg_be,
  output logic                reg_wr,
  output logic                reg_rd,
  output logic [LANE_W-1:0]   reg_wdata,
  input  logic [LANE_W-1:0]   reg_rdata,
  output logic [MAW-1:0]      mem_addr,
  output logic [1:0]          mem_be,
  output logic                mem_wr,
  output logic                mem_rd,
  output logic [LANE_W-1:0]   mem_wdata,
  input  logic [LANE_W-1:0]   mem_rdata
);
  logic               rst_sync_n;
  logic [STRAP_W-1:0] strap_q;
  strap_t             strap;
  logic [1:0]         be;
  logic [LANE_W-1:0]  lane_wdata, rd_lanes, io_rd_lanes, host_rdata;
  logic               io_rd_hit, mem_hit, mem_act, waiting;

  hbus_reset_strap #(.SW(STRAP_W), .SYNC_DEPTH(2)) u_strap (
    .clk(clk), .rst_n(rst_n), .cfg_pins(cfg_pins),
    .rst_sync_n(rst_sync_n), .strap_q(strap_q)
  );

  assign strap = strap_t'(strap_q);

  hbus_lane_steer #(.BW(BYTE_W)) u_steer (
    .wide(strap.wide), .swap(strap.swap), .a0(addr[0]), .bhe_n(bhe_n),
    .host_wdata(dbus_in), .lane_rdata(rd_lanes),
    .be(be), .lane_wdata(lane_wdata), .host_rdata(host_rdata)
  );

  hbus_io_decode #(.IO_AW(IO_AW), .NREG(NREG), .BW(BYTE_W)) u_io (
    .clk(clk), .rst_sync_n(rst_sync_n), .active(rst_sync_n),
    .direct(strap.direct), .io_base(strap.io_base), .addr(addr[IO_AW-1:0]),
    .io_cs_n(io_cs_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .be(be), .lane_wdata(lane_wdata), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .rd_lanes(io_rd_lanes), .rd_hit(io_rd_hit)
  );

  assign mem_hit = rst_sync_n & ~mem_cs_n & (addr[ADDR_W-1:MAW+1] == strap.mem_tag);
  assign mem_act = mem_hit & (~mem_rd_n | ~mem_wr_n);

  hbus_mem_wait #(.CW(WAIT_W)) u_wait (
    .clk(clk), .rst_sync_n(rst_sync_n), .mem_act(mem_act),
    .wait_clks(mem_wait), .waiting(waiting)
  );

  assign mem_wr    = mem_act & ~mem_wr_n & ~waiting;
  assign mem_rd    = mem_act & ~mem_rd_n & ~waiting;
  assign mem_addr  = addr[MAW:1];
  assign mem_be    = mem_act ? be : 2'b00;
  assign mem_wdata = lane_wdata;

  assign ready_oe  = waiting;
  assign ready_o   = ~waiting;

  assign rd_lanes  = io_rd_hit ? io_rd_lanes : mem_rdata;
  assign dbus_oe   = io_rd_hit | mem_rd;
  assign dbus_out  = dbus_oe ? host_rdata : '0;
endmodule

// File: rtl/hbus_decoder_chk.sv
module hbus_decoder_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [15:0] strap_q,
  input logic        mem_cs_n,
  input logic        mem_rd_n,
  input logic        mem_wr_n,
  input logic        io_rd_n,
  input logic [3:0]  mem_wait,
  input logic        ready_oe,
  input logic        mem_wr,
  input logic        mem_rd,
  input logic [1:0]  mem_be,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_be,
  input logic        dbus_oe
);
  logic [4:0] wait_run;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   wait_run <= '0;
    else if (ready_oe) wait_run <= wait_run + 1'b1;
    else               wait_run <= '0;
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> $stable(strap_q)); // R1

  AST_WAIT_IN_MEM_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready_oe |-> (!mem_cs_n && (!mem_rd_n || !mem_wr_n))); // R9

  AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready_oe |-> (wait_run < {1'b0, mem_wait})); // R9

  AST_NO_STROBE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready_oe |-> !(mem_wr || mem_rd)); // R10

  AST_NARROW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strap_q[0] && (mem_wr || mem_rd)) |-> $onehot(mem_be)); // R3

  AST_NARROW_REG_LANE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!strap_q[0] && (reg_wr || reg_rd)) |-> $onehot(reg_be)); // R3

  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbus_oe |-> (!io_rd_n || !mem_rd_n)); // R11
endmodule

bind hbus_decoder hbus_decoder_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .strap_q(strap_q),
  .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .io_rd_n(io_rd_n), .mem_wait(mem_wait), .ready_oe(ready_oe),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_be(mem_be),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be), .dbus_oe(dbus_oe)
);

// File: tb/hbus_decoder_tb.sv
module hbus_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_pins;
  logic        io_cs_n, io_rd_n, io_wr_n, mem_cs_n, mem_rd_n, mem_wr_n, bhe_n;
  logic [19:0] addr;
  logic [15:0] dbus_in, dbus_out;
  logic        dbus_oe, ready_o, ready_oe;
  logic [3:0]  mem_wait;
  logic [3:0]  reg_addr;
  logic [1:0]  reg_be, mem_be;
  logic        reg_wr, reg_rd, mem_wr, mem_rd;
  logic [15:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic [15:0] regs [16];
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  hbus_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pins(cfg_pins),
    .io_cs_n(io_cs_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .bhe_n(bhe_n), .addr(addr), .dbus_in(dbus_in), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe), .mem_wait(mem_wait), .ready_o(ready_o), .ready_oe(ready_oe),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // external register file and memory models
  assign reg_rdata = regs[reg_addr];
  assign mem_rdata = mem_addr ^ 16'hC3C3;
  always @(posedge clk) begin
    if (reg_wr) begin
      if (reg_be[0]) regs[reg_addr][7:0]  <= reg_wdata[7:0];
      if (reg_be[1]) regs[reg_addr][15:8] <= reg_wdata[15:8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    io_cs_n = 1; io_rd_n = 1; io_wr_n = 1;
    mem_cs_n = 1; mem_rd_n = 1; mem_wr_n = 1; bhe_n = 1;
    #1;
  endtask

  task automatic bus(input bit is_mem, input bit wr, input logic [19:0] a,
                     input logic bhe, input logic [15:0] d);
    @(negedge clk);
    addr = a; bhe_n = bhe; dbus_in = d;
    if (is_mem) begin mem_cs_n = 0; mem_wr_n = ~wr; mem_rd_n = wr; end
    else        begin io_cs_n  = 0; io_wr_n  = ~wr; io_rd_n  = wr; end
    #2;
  endtask

  task automatic do_reset(input logic [15:0] cfg);
    idle();
    rst_n = 0; cfg_pins = cfg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cfg_pins = ~cfg;   // later strap changes must not matter (R1)
  endtask

  task automatic t_reset_state();
    rst_n = 0; cfg_pins = 16'hB803; mem_wait = 4'd2;
    addr = 20'hA0306; dbus_in = 16'h1111; bhe_n = 0;
    io_cs_n = 0; io_wr_n = 0; io_rd_n = 1;
    mem_cs_n = 0; mem_rd_n = 0; mem_wr_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reg_wr", reg_wr, 0);
    chk("R2 mem_rd", mem_rd, 0);
    chk("R2 dbus_oe", dbus_oe, 0);
    chk("R2 ready_oe", ready_oe, 0);
  endtask

  task automatic t_direct16();
    do_reset(16'hB803);   // 16-bit, direct, no swap, base 0x300, tag 5
    bus(0, 1, 20'h00306, 0, 16'h1234);
    chk("R6 reg_addr", reg_addr, 3);
    chk("R4 reg_be word", reg_be, 2'b11);
    chk("R6 reg_wr", reg_wr, 1);
    chk("R4 reg_wdata", reg_wdata, 16'h1234);
    idle();
    bus(0, 0, 20'h00306, 0, 16'h0);
    chk("R11 dbus_oe read", dbus_oe, 1);
    chk("R6 read data", dbus_out, 16'h1234);
    idle();
    bus(0, 1, 20'h0031F, 0, 16'h9900);
    chk("R4 odd-only be", reg_be, 2'b10);
    chk("R6 last register", reg_addr, 15);
    idle();
    bus(0, 1, 20'h00320, 0, 16'h0);
    chk("R6 above range ignored", reg_wr, 0);
    idle();
    bus(0, 1, 20'h002FE, 0, 16'h0);
    chk("R6 below base ignored", reg_wr, 0);
    idle();
    chk("R1 straps kept after pin change", regs[3], 16'h1234);
  endtask

  task automatic t_mem16();
    mem_wait = 4'd3;
    bus(1, 1, 20'hA0010, 0, 16'hBEEF);
    for (int i = 0; i < 3; i++) begin
      chk("R9 ready driven", {ready_oe, ready_o}, 2'b10);
      chk("R10 strobe held", mem_wr, 0);
      @(negedge clk); #2;
    end
    chk("R9 ready released", ready_oe, 0);
    chk("R10 strobe after wait", mem_wr, 1);
    chk("R8 word address", mem_addr, 16'h0008);
    chk("R4 mem be", mem_be, 2'b11);
    chk("R4 mem wdata", mem_wdata, 16'hBEEF);
    idle();
    mem_wait = 4'd0;
    bus(1, 0, 20'hA0021, 0, 16'h0);
    chk("R9 no wait at zero", ready_oe, 0);
    chk("R10 read at once", mem_rd, 1);
    chk("R4 odd lane only", mem_be, 2'b10);
    chk("R11 mem read data", dbus_out, 16'h0010 ^ 16'hC3C3);
    idle();
    mem_wait = 4'd2;
    bus(1, 0, 20'hC0000, 0, 16'h0);
    chk("R8 outside window no wait", ready_oe, 0);
    @(negedge clk); #2;
    chk("R8 outside window no read", mem_rd, 0);
    chk("R11 no drive outside", dbus_oe, 0);
    idle();
  endtask

  task automatic t_swap16();
    do_reset(16'hB80B);   // as before plus byte swap
    bus(0, 1, 20'h00300, 0, 16'h1234);
    chk("R5 swapped write", reg_wdata, 16'h3412);
    idle();
    bus(0, 0, 20'h00300, 0, 16'h0);
    chk("R5 swapped read", dbus_out, 16'h1234);
    idle();
  endtask

  task automatic t_index8();
    do_reset(16'h1F08);   // 8-bit, indexed, swap bit set, base 0x3E0, tag 0
    mem_wait = 4'd0;
    bus(0, 1, 20'h003E0, 0, 16'hFF07);   // index: reg 3, high byte
    chk("R7 index write not a reg write", reg_wr, 0);
    idle();
    @(negedge clk);
    bus(0, 1, 20'h003E1, 0, 16'hFF5A);
    chk("R7 indexed reg", reg_addr, 3);
    chk("R3 indexed lane", reg_be, 2'b10);
    chk("R3 upper data ignored", reg_wdata, 16'h5A5A);
    idle();
    bus(0, 0, 20'h003E0, 0, 16'h0);
    chk("R7 index readback", dbus_out, 16'h0007);
    idle();
    bus(0, 0, 20'h003E1, 0, 16'h0);
    chk("R7 indexed byte read", dbus_out, 16'h005A);
    idle();
    bus(0, 1, 20'h003E2, 0, 16'h0);
    chk("R7 other word ignored", reg_wr, 0);
    idle();
    bus(1, 0, 20'h00005, 0, 16'h0);
    chk("R3 odd byte be", mem_be, 2'b10);
    chk("R3 odd byte data", dbus_out, {8'h00, 8'hC3});
    idle();
    bus(1, 0, 20'h00004, 0, 16'h0);
    chk("R3 even byte data no swap", dbus_out, {8'h00, 8'hC1});
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 16'h0;
    t_reset_state();
    t_direct16();
    t_mem16();
    t_swap16();
    t_index8();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule